// File: doc/BRIEF.md
# Host Command and Modifier Decoder

This block sits behind a parallel-port style host link once the adapter has been selected. The host presents a byte on a shared bus and marks it with one of two strobes: a command strobe or a data strobe. A command byte either selects a target for the data strobes that follow, or acts as a prefix that sets or clears bits in a transfer-modifier register. A target is an internal register or a port on the attached external device, and each target is opened for read or for write.

Data strobes then act on the selected target. Writes to an external port come out as a one-cycle write pulse with address and data. Reads return a byte, together with a valid pulse, from either the external device or the internal register file. The internal file holds a status byte, a fixed version byte, a RAM-size byte, a 24-bit block length and two external output bits. The current modifier bits for 16-bit I/O, fast-write and block transfer are driven out continuously for the transfer engine.

Top module: `cp_decoder`

## Requirements
- R1: After reset all three modifier outputs are 0, ext_out is 0, blk_len is 0, ext_wr and host_rvalid are low, and the RAM-size register holds 0x02.
- R2: A command whose top three bits are 111 sets modifier bits from its low bits: bit 0 sets io16, bit 2 sets fastwr, bit 3 sets blk. Bits 1 and 4 have no effect, and bits not named stay unchanged.
- R3: A command whose top three bits are 110 clears the modifiers named by the same bit positions. A prefix command, set or clear, does not change the selected target, so later data strobes still act on the previous access command.
- R4: Any other command selects a target. Bit 6 = 1 selects an external port, bit 5 = 1 selects write, and bits 3:0 give the port address, with bit 3 driven out as the control-block select. A data strobe on an external write target makes ext_wr high for exactly the following cycle, with ext_wdata equal to the strobed byte.
- R5: A data strobe on an external read target drives ext_rd high during the strobe cycle. In the next cycle host_rvalid is high and host_rdata equals the ext_rdata sampled at the strobe.
- R6: With bit 6 = 0, bits 4:0 address an internal register. A read of address 0 returns irq_in in bit 0 and zeros elsewhere.
- R7: A read of address 1 returns the version constant 0x0C. A write to address 1 loads ext_out from data bits 7:6 and leaves the version value unchanged.
- R8: Address 3 is the RAM-size register, which can be read and written. Reads of unmapped internal addresses return 0.
- R9: Address 8 is the block length. Successive data writes fill bytes 0, 1 and 2 of blk_len (low byte first), and any further writes are ignored until a new access command is latched, which restarts at byte 0.
- R10: Data strobes before the first access command after reset are ignored. When both strobes are high in the same cycle, the command is taken and the data strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_data | input | 8 | Byte presented by the host |
| cmd_stb | input | 1 | One-cycle command strobe |
| dat_stb | input | 1 | One-cycle data strobe |
| irq_in | input | 1 | Peripheral interrupt line |
| ext_rdata | input | 8 | Read data from the external device |
| host_rdata | output | 8 | Byte returned to the host |
| host_rvalid | output | 1 | host_rdata is valid this cycle |
| ext_addr | output | 4 | Selected external port address |
| ext_ctl_sel | output | 1 | Control block selected (address bit 3) |
| ext_wr | output | 1 | External write pulse |
| ext_wdata | output | 8 | External write data |
| ext_rd | output | 1 | External read request |
| mod_io16 | output | 1 | 16-bit I/O modifier |
| mod_fastwr | output | 1 | Fast-write modifier |
| mod_blk | output | 1 | Block-transfer modifier |
| blk_len | output | 24 | Block transfer length |
| ext_out | output | 2 | External output control bits |

## Verification
Modifier bits, the selected address, internal register contents, ext_wr and host_rvalid/host_rdata all settle one clock edge after the strobe that causes them. ext_rd is combinational and is valid while the data strobe is high. The bench drives strobes on the falling edge and lowers them on the next falling edge. It checks ext_rd partway into the strobe cycle, and checks the registered results on that next falling edge, one rising edge after the strobe. A second check one cycle later confirms that the write pulse lasts only a single cycle.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    typedef enum logic [1:0] {
        OP_ACCESS  = 2'd0,
        OP_PFX_SET = 2'd1,
        OP_PFX_CLR = 2'd2
    } op_e;

    typedef struct packed {
        logic       ext;
        logic       wr;
        logic [4:0] addr;
    } acc_t;

    typedef struct packed {
        logic blk;
        logic fastwr;
        logic io16;
    } mods_t;

    localparam logic [4:0] RA_STATUS = 5'd0;
    localparam logic [4:0] RA_VER    = 5'd1;
    localparam logic [4:0] RA_RAM    = 5'd3;
    localparam logic [4:0] RA_LEN    = 5'd8;

endpackage

// File: rtl/cpd_classify.sv
module cpd_classify
    import cpd_pkg::*;
(
    input  logic [7:0] cmd,
    output op_e        op,
    output acc_t       acc,
    output mods_t      mask
);
    always_comb begin
        unique case (cmd[7:5])
            3'b111:  op = OP_PFX_SET;
            3'b110:  op = OP_PFX_CLR;
            default: op = OP_ACCESS;
        endcase
        acc.ext     = cmd[6];
        acc.wr      = cmd[5];
        acc.addr    = cmd[4:0];
        mask.io16   = cmd[0];
        mask.fastwr = cmd[2];
        mask.blk    = cmd[3];
    end
endmodule

// File: rtl/cpd_prefix_reg.sv
module cpd_prefix_reg
    import cpd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  set_en,
    input  logic  clr_en,
    input  mods_t mask,
    output mods_t mods
);
    typedef struct packed {
        mods_t mods;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en)
            st_d.mods = st_q.mods | mask;
        else if (clr_en)
            st_d.mods = st_q.mods & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mods = st_q.mods;

    // R3: without a prefix command the modifiers hold
    p_prefix_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mods));

    // R2: a set never clears a bit
    p_set_no_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mods & $past(mods)) == $past(mods)));
endmodule

// File: rtl/cpd_intregs.sv
module cpd_intregs
    import cpd_pkg::*;
#(
    parameter logic [7:0] VERSION   = 8'h0C,
    parameter logic [7:0] RAM_RESET = 8'h02,
    parameter int         LEN_BYTES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_new,
    input  logic                   wr_en,
    input  logic [4:0]             addr,
    input  logic [7:0]             wdata,
    input  logic                   irq,
    output logic [7:0]             rdata,
    output logic [8*LEN_BYTES-1:0] blk_len,
    output logic [1:0]             ext_out
);
    localparam int IDXW = $clog2(LEN_BYTES + 1);

    typedef struct packed {
        logic [7:0]                ram;
        logic [1:0]                ext_out;
        logic [LEN_BYTES-1:0][7:0] len;
        logic [IDXW-1:0]           idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_new) begin
            st_d.idx = '0;
        end else if (wr_en) begin
            unique case (addr)
                RA_VER: st_d.ext_out = wdata[7:6];
                RA_RAM: st_d.ram     = wdata;
                RA_LEN: begin
                    for (int i = 0; i < LEN_BYTES; i++)
                        if (st_q.idx == IDXW'(i)) st_d.len[i] = wdata;
                    if (st_q.idx < IDXW'(LEN_BYTES))
                        st_d.idx = st_q.idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ram <= RAM_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (addr)
            RA_STATUS: rdata = {7'b0, irq};
            RA_VER:    rdata = VERSION;
            RA_RAM:    rdata = st_q.ram;
            default:   rdata = 8'h00;
        endcase
    end

    for (genvar g = 0; g < LEN_BYTES; g++) begin : g_len
        assign blk_len[8*g +: 8] = st_q.len[g];
    end

    assign ext_out = st_q.ext_out;

    // R7: ext_out moves only on a write to the version address
    p_extout_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_out != $past(ext_out)) |-> $past(wr_en && addr == RA_VER));

    // R9: length bytes change only on a length write
    p_len_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_len != $past(blk_len)) |-> $past(wr_en && addr == RA_LEN && !sel_new));
endmodule

// File: rtl/cp_decoder.sv
module cp_decoder
    import cpd_pkg::*;
#(
    parameter logic [7:0] VERSION   = 8'h0C,
    parameter logic [7:0] RAM_RESET = 8'h02,
    parameter int         LEN_BYTES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             host_data,
    input  logic                   cmd_stb,
    input  logic                   dat_stb,
    input  logic                   irq_in,
    input  logic [7:0]             ext_rdata,
    output logic [7:0]             host_rdata,
    output logic                   host_rvalid,
    output logic [3:0]             ext_addr,
    output logic                   ext_ctl_sel,
    output logic                   ext_wr,
    output logic [7:0]             ext_wdata,
    output logic                   ext_rd,
    output logic                   mod_io16,
    output logic                   mod_fastwr,
    output logic                   mod_blk,
    output logic [8*LEN_BYTES-1:0] blk_len,
    output logic [1:0]             ext_out
);
    typedef struct packed {
        logic       cmd_valid;
        acc_t       acc;
        logic       ext_wr;
        logic [7:0] wdata;
        logic [7:0] rdata;
        logic       rvalid;
    } st_t;

    st_t   st_d, st_q;
    op_e   op;
    acc_t  acc_in;
    mods_t mask, mods;
    logic  take_dat, sel_new, pfx_set, pfx_clr, int_wr, rd_hit;
    logic [7:0] int_rdata;

    cpd_classify u_cls (
        .cmd  (host_data),
        .op   (op),
        .acc  (acc_in),
        .mask (mask)
    );

    cpd_prefix_reg u_pfx (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (pfx_set),
        .clr_en (pfx_clr),
        .mask   (mask),
        .mods   (mods)
    );

    cpd_intregs #(
        .VERSION   (VERSION),
        .RAM_RESET (RAM_RESET),
        .LEN_BYTES (LEN_BYTES)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_new (sel_new),
        .wr_en   (int_wr),
        .addr    (st_q.acc.addr),
        .wdata   (host_data),
        .irq     (irq_in),
        .rdata   (int_rdata),
        .blk_len (blk_len),
        .ext_out (ext_out)
    );

    always_comb begin
        take_dat = dat_stb && !cmd_stb && st_q.cmd_valid;
        sel_new  = cmd_stb && (op == OP_ACCESS);
        pfx_set  = cmd_stb && (op == OP_PFX_SET);
        pfx_clr  = cmd_stb && (op == OP_PFX_CLR);
        int_wr   = take_dat && st_q.acc.wr && !st_q.acc.ext;
        rd_hit   = take_dat && !st_q.acc.wr;
        ext_rd   = rd_hit && st_q.acc.ext;

        st_d        = st_q;
        st_d.ext_wr = take_dat && st_q.acc.wr && st_q.acc.ext;
        st_d.rvalid = rd_hit;
        if (sel_new) begin
            st_d.cmd_valid = 1'b1;
            st_d.acc       = acc_in;
        end
        if (st_d.ext_wr)
            st_d.wdata = host_data;
        if (rd_hit)
            st_d.rdata = st_q.acc.ext ? ext_rdata : int_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata  = st_q.rdata;
    assign host_rvalid = st_q.rvalid;
    assign ext_addr    = st_q.acc.addr[3:0];
    assign ext_ctl_sel = st_q.acc.addr[3];
    assign ext_wr      = st_q.ext_wr;
    assign ext_wdata   = st_q.wdata;
    assign mod_io16    = mods.io16;
    assign mod_fastwr  = mods.fastwr;
    assign mod_blk     = mods.blk;

    // R4: a write pulse follows a data strobe taken without a command
    p_wr_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |-> $past(dat_stb && !cmd_stb));

    // R4: the write pulse lasts one cycle unless strobes come back to back
    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_wr && !dat_stb) |=> !ext_wr);

    // R5: read data valid follows a data strobe
    p_rvalid_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(dat_stb && !cmd_stb));

    // R5: read request and write pulse never coincide
    p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr));

    // R10: the command strobe always wins over the data strobe
    p_cmd_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && dat_stb) |=> (!ext_wr && !host_rvalid));
endmodule

// File: tb/cp_decoder_test.sv
module cp_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_data = 8'h00;
    logic        cmd_stb = 1'b0;
    logic        dat_stb = 1'b0;
    logic        irq_in = 1'b0;
    logic [7:0]  ext_rdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic [3:0]  ext_addr;
    logic        ext_ctl_sel;
    logic        ext_wr;
    logic [7:0]  ext_wdata;
    logic        ext_rd;
    logic        mod_io16, mod_fastwr, mod_blk;
    logic [23:0] blk_len;
    logic [1:0]  ext_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cp_decoder uut (
        .clk(clk), .rst_n(rst_n), .host_data(host_data), .cmd_stb(cmd_stb),
        .dat_stb(dat_stb), .irq_in(irq_in), .ext_rdata(ext_rdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .ext_addr(ext_addr),
        .ext_ctl_sel(ext_ctl_sel), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
        .ext_rd(ext_rd), .mod_io16(mod_io16), .mod_fastwr(mod_fastwr),
        .mod_blk(mod_blk), .blk_len(blk_len), .ext_out(ext_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] modv();
        return {29'b0, mod_blk, mod_fastwr, mod_io16};
    endfunction

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk); host_data = b; cmd_stb = 1'b1;
        @(negedge clk); cmd_stb = 1'b0;
    endtask

    task automatic send_dat(input logic [7:0] b);
        @(negedge clk); host_data = b; dat_stb = 1'b1;
        @(negedge clk); dat_stb = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic exp_rd, input logic [7:0] exp);
        @(negedge clk); dat_stb = 1'b1;
        #1 chk({tag, " ext_rd"}, 32'(ext_rd), 32'(exp_rd));
        @(negedge clk); dat_stb = 1'b0;
        chk({tag, " rvalid"}, 32'(host_rvalid), 32'd1);
        chk({tag, " rdata"}, 32'(host_rdata), 32'(exp));
    endtask

    task automatic t_reset();
        chk("R1 mods", modv(), 32'd0);
        chk("R1 ext_out", 32'(ext_out), 32'd0);
        chk("R1 blk_len", 32'(blk_len), 32'd0);
        chk("R1 ext_wr", 32'(ext_wr), 32'd0);
        chk("R1 rvalid", 32'(host_rvalid), 32'd0);
        send_dat(8'h5A);   // R10: no command yet
        chk("R10 early strobe ext_wr", 32'(ext_wr), 32'd0);
        chk("R10 early strobe rvalid", 32'(host_rvalid), 32'd0);
        send_cmd(8'h03);
        read_chk("R1 ram reset", 1'b0, 8'h02);
    endtask

    task automatic t_prefix();
        send_cmd(8'hED);
        chk("R2 set 0,2,3", modv(), 32'd7);
        send_cmd(8'hC4);
        chk("R3 clear fastwr", modv(), 32'd5);
        send_cmd(8'hF2);
        chk("R2 bits 1,4 ignored", modv(), 32'd5);
        send_cmd(8'hE4);
        chk("R2 set fastwr", modv(), 32'd7);
        send_cmd(8'hC9);
        chk("R3 clear io16 blk", modv(), 32'd2);
        send_cmd(8'hC4);
        chk("R3 all clear", modv(), 32'd0);
    endtask

    task automatic t_ext_write();
        send_cmd(8'h6B);
        chk("R4 ext_addr", 32'(ext_addr), 32'hB);
        chk("R4 ctl_sel", 32'(ext_ctl_sel), 32'd1);
        send_dat(8'hA5);
        chk("R4 ext_wr pulse", 32'(ext_wr), 32'd1);
        chk("R4 ext_wdata", 32'(ext_wdata), 32'hA5);
        @(negedge clk);
        chk("R4 pulse ends", 32'(ext_wr), 32'd0);
        send_cmd(8'hE1);
        chk("R3 prefix io16", 32'(mod_io16), 32'd1);
        send_dat(8'h3C);
        chk("R3 target kept ext_wr", 32'(ext_wr), 32'd1);
        chk("R3 target kept data", 32'(ext_wdata), 32'h3C);
        chk("R3 target kept addr", 32'(ext_addr), 32'hB);
        send_cmd(8'hC1);
    endtask

    task automatic t_ext_read();
        send_cmd(8'h42);
        chk("R4 ctl_sel low", 32'(ext_ctl_sel), 32'd0);
        ext_rdata = 8'h9E;
        read_chk("R5 ext read", 1'b1, 8'h9E);
        chk("R5 no write", 32'(ext_wr), 32'd0);
    endtask

    task automatic t_status();
        send_cmd(8'h00);
        irq_in = 1'b1;
        read_chk("R6 irq high", 1'b0, 8'h01);
        irq_in = 1'b0;
        read_chk("R6 irq low", 1'b0, 8'h00);
    endtask

    task automatic t_version();
        send_cmd(8'h01);
        read_chk("R7 version", 1'b0, 8'h0C);
        send_cmd(8'h21);
        send_dat(8'hD5);
        chk("R7 ext_out 3", 32'(ext_out), 32'd3);
        chk("R4 internal write no pulse", 32'(ext_wr), 32'd0);
        send_dat(8'h40);
        chk("R7 ext_out 1", 32'(ext_out), 32'd1);
        send_cmd(8'h01);
        read_chk("R7 version kept", 1'b0, 8'h0C);
    endtask

    task automatic t_ram();
        send_cmd(8'h23);
        send_dat(8'h05);
        send_cmd(8'h03);
        read_chk("R8 ram rw", 1'b0, 8'h05);
        send_cmd(8'h07);
        read_chk("R8 unmapped", 1'b0, 8'h00);
    endtask

    task automatic t_len();
        send_cmd(8'h28);
        send_dat(8'h34);
        chk("R9 byte0", 32'(blk_len), 32'h000034);
        send_dat(8'h12);
        send_dat(8'h00);
        chk("R9 three bytes", 32'(blk_len), 32'h001234);
        send_dat(8'h77);
        chk("R9 fourth ignored", 32'(blk_len), 32'h001234);
        send_cmd(8'h28);
        send_dat(8'hAB);
        chk("R9 restart low", 32'(blk_len), 32'h0012AB);
    endtask

    task automatic t_collide();
        send_cmd(8'h6B);
        @(negedge clk); host_data = 8'h62; cmd_stb = 1'b1; dat_stb = 1'b1;
        @(negedge clk); cmd_stb = 1'b0; dat_stb = 1'b0;
        chk("R10 data ignored", 32'(ext_wr), 32'd0);
        chk("R10 command taken", 32'(ext_addr), 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prefix();
        t_ext_write();
        t_ext_read();
        t_status();
        t_version();
        t_ram();
        t_len();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule